// File: doc/BRIEF.md
# Sleep Power Manager Register Block

This block is the software-visible side of a chip power manager. A word-addressed read/write bus reaches eight 32-bit registers. Through them software asks for sleep, reads why the last sleep happened, keeps one word of data across sleep, and picks which wake lines may end sleep. It also holds opaque configuration words for neighbouring logic and the output levels the GPIO pins take while asleep. The block also shows whether the slow 32.768 kHz oscillator has settled since the last hardware reset.

Sleep is requested through a set-only bit that hardware clears again at wake-up. On the way into sleep the GPIO outputs switch from their normal-mode values to a snapshot of the programmed sleep levels. They switch back at wake-up, and a wake pulse lasting one clock is produced.

The bus is a single-cycle access. A write is taken at the clock edge while `bus_sel_i` and `bus_wr_i` are high. Read data is combinational and valid in the same cycle while `bus_sel_i` is high and `bus_wr_i` is low. Outside a read, the read data bus is zero.

Top module: `sleep_pwr_regs`

## Requirements
- R1: After a synchronous reset every register reads zero, except the PLL field, which reads its reset parameter (default 7). `sleep_o`, `wake_pulse_o` and the sleep request are low, and `gpio_o` equals `gpio_norm_i`.
- R2: Writing a word with bit 0 set to offset 0x00 (control) sets the sleep request bit, which reads back in bit 0 at offset 0x00. `sleep_o` rises at the clock edge after the request bit is set, so the request bit leads `sleep_o` by one cycle.
- R3: Writing 0 to bit 0 of the control register leaves the request bit unchanged. Unimplemented bits read zero and ignore writes: control and status bits 31..1, wake-enable bits above NUM_WAKE, configuration bits above CFG_W, PLL bits above PLL_W, GPIO sleep bits above NUM_GPIO, and oscillator status bits 31..1.
- R4: While asleep, a wake event clears the request bit and drops `sleep_o` at the same clock edge.
- R5: A wake line ends sleep only if its bit is set in the wake-enable register at offset 0x0C. Wake lines have no effect while awake.
- R6: Entering sleep on the software request sets status bit 0 at offset 0x04. Writing 1 to that bit clears it and writing 0 leaves it set. A set on entry wins over a clear in the same cycle.
- R7: The scratch word at offset 0x08 stores all 32 bits and keeps its value through sleep and wake.
- R8: When sleep is entered, `gpio_o` takes a snapshot of the GPIO sleep register at offset 0x18 and holds it until wake, even if that register is rewritten during sleep. While awake, `gpio_o` follows `gpio_norm_i`.
- R9: Each wake-up produces a `wake_pulse_o` that is high for exactly one cycle: the cycle right after the edge that ends sleep.
- R10: Bit 0 of offset 0x1C reads 1 once `osc_stable_i` has passed through a synchronizer of SYNC_STAGES flops. It then stays 1 until reset, whatever the input does, and is read-only.
- R11: The register index comes from address bits 4..2, and address bits 1..0 are ignored. Any address with a bit above bit 4 set is unmapped: it reads zero and a write to it changes nothing.
- R12: The configuration register (offset 0x10) and the PLL register (offset 0x14) are read/write and drive `cfg_o` and `pll_cfg_o` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high hardware reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the read cycle |
| wake_i | input | NUM_WAKE | Wake event lines |
| gpio_norm_i | input | NUM_GPIO | GPIO levels used while awake |
| gpio_o | output | NUM_GPIO | GPIO levels driven to the pads |
| osc_stable_i | input | 1 | Slow oscillator settled indication (asynchronous) |
| sleep_o | output | 1 | High while in sleep mode |
| wake_pulse_o | output | 1 | One-cycle pulse after wake-up |
| cfg_o | output | CFG_W | General configuration field |
| pll_cfg_o | output | PLL_W | PLL configuration field |

## Verification
The bench writes 0 to a request bit that is already set. A design that treated bit 0 as plain read/write would drop the request there. The bench also rewrites the GPIO sleep register mid-sleep, which exposes a live mux in place of an entry snapshot, because the pins would change while asleep. It raises a wake line that is not enabled, then an enabled one while awake. A design that missed the enable mask, or woke from the awake state, would give a spurious `wake_pulse_o` or leave sleep early. The bench also checks that status and oscillator bits survive the wrong kind of write, and that a reset in the middle of sleep clears both sleep and the sticky oscillator flag.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam int DATA_W    = 32;
    localparam int REG_IDX_W = 3;

    // Word index of each register; address bits 4..2 select it.
    typedef enum logic [REG_IDX_W-1:0] {
        REG_CTRL     = 3'd0,
        REG_STAT     = 3'd1,
        REG_SCRATCH  = 3'd2,
        REG_WAKE_EN  = 3'd3,
        REG_CFG      = 3'd4,
        REG_PLL      = 3'd5,
        REG_GPIO_SLP = 3'd6,
        REG_OSC      = 3'd7
    } pmr_reg_e;

    typedef enum logic {
        PM_AWAKE  = 1'b0,
        PM_ASLEEP = 1'b1
    } pmr_state_e;

    // Decoded bus access for one cycle.
    typedef struct packed {
        logic     rd;
        logic     wr;
        logic     hit;
        pmr_reg_e idx;
    } pmr_access_s;

    localparam int FORCE_BIT = 0;
    localparam int CAUSE_BIT = 0;
    localparam int OSC_BIT   = 0;

    function automatic logic [DATA_W-1:0] flag_word(input logic flag);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = flag;
        return w;
    endfunction

endpackage

// File: rtl/pmr_addr_decode.sv
module pmr_addr_decode
    import pmr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-3:0] word_addr_i,
    output pmr_access_s       acc_o
);

    logic hit;

    generate
        if (ADDR_W > 5) begin : g_upper
            assign hit = (word_addr_i[ADDR_W-3:REG_IDX_W] == '0);
        end else begin : g_full
            assign hit = 1'b1;
        end
    endgenerate

    always_comb begin
        acc_o.rd  = sel_i & ~wr_i & hit;
        acc_o.wr  = sel_i &  wr_i & hit;
        acc_o.hit = hit;
        acc_o.idx = pmr_reg_e'(word_addr_i[REG_IDX_W-1:0]);
    end

endmodule

// File: rtl/pmr_sleep_fsm.sv
module pmr_sleep_fsm
    import pmr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic force_i,
    input  logic wake_hit_i,
    output logic asleep_o,
    output logic enter_o,
    output logic wake_o,
    output logic wake_pulse_o
);

    pmr_state_e state_q, state_d;
    logic       pulse_q;

    always_comb begin
        state_d = state_q;
        enter_o = 1'b0;
        wake_o  = 1'b0;
        unique case (state_q)
            PM_AWAKE: begin
                if (force_i) begin
                    state_d = PM_ASLEEP;
                    enter_o = 1'b1;
                end
            end
            PM_ASLEEP: begin
                if (wake_hit_i) begin
                    state_d = PM_AWAKE;
                    wake_o  = 1'b1;
                end
            end
            default: state_d = PM_AWAKE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PM_AWAKE;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= wake_o;
        end
    end

    assign asleep_o     = (state_q == PM_ASLEEP);
    assign wake_pulse_o = pulse_q;

endmodule

// File: rtl/pmr_gpio_mux.sv
module pmr_gpio_mux #(
    parameter int NUM_GPIO = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                capture_i,
    input  logic                asleep_i,
    input  logic [NUM_GPIO-1:0] slp_val_i,
    input  logic [NUM_GPIO-1:0] norm_i,
    output logic [NUM_GPIO-1:0] gpio_o
);

    generate
        for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
            logic snap_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    snap_q <= 1'b0;
                end else if (capture_i) begin
                    snap_q <= slp_val_i[g];
                end
            end
            assign gpio_o[g] = asleep_i ? snap_q : norm_i[g];
        end
    endgenerate

endmodule

// File: rtl/pmr_osc_sync.sv
module pmr_osc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sticky_o
);

    logic synced;
    logic sticky_q;

    generate
        if (STAGES <= 1) begin : g_one
            logic s_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) s_q <= 1'b0;
                else       s_q <= async_i;
            end
            assign synced = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] s_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) s_q <= '0;
                else       s_q <= {s_q[STAGES-2:0], async_i};
            end
            assign synced = s_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) sticky_q <= 1'b0;
        else       sticky_q <= sticky_q | synced;
    end

    assign sticky_o = sticky_q;

endmodule

// File: rtl/sleep_pwr_regs.sv
module sleep_pwr_regs
    import pmr_pkg::*;
#(
    parameter int              ADDR_W      = 6,
    parameter int              NUM_WAKE    = 8,
    parameter int              NUM_GPIO    = 8,
    parameter int              CFG_W       = 4,
    parameter int              PLL_W       = 5,
    parameter logic [PLL_W-1:0] PLL_RST    = 5'd7,
    parameter int              SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    input  logic [NUM_WAKE-1:0] wake_i,
    input  logic [NUM_GPIO-1:0] gpio_norm_i,
    output logic [NUM_GPIO-1:0] gpio_o,
    input  logic                osc_stable_i,
    output logic                sleep_o,
    output logic                wake_pulse_o,
    output logic [CFG_W-1:0]    cfg_o,
    output logic [PLL_W-1:0]    pll_cfg_o
);

    pmr_access_s acc;

    logic                force_q;
    logic                cause_q;
    logic [DATA_W-1:0]   scratch_q;
    logic [NUM_WAKE-1:0] wake_en_q;
    logic [CFG_W-1:0]    cfg_q;
    logic [PLL_W-1:0]    pll_q;
    logic [NUM_GPIO-1:0] gpio_slp_q;
    logic                osc_ok_q;

    logic asleep, enter, wake_evt;
    logic [DATA_W-1:0] rd_word;

    logic unused_addr_lsb;
    assign unused_addr_lsb = ^bus_addr_i[1:0];

    pmr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel_i       (bus_sel_i),
        .wr_i        (bus_wr_i),
        .word_addr_i (bus_addr_i[ADDR_W-1:2]),
        .acc_o       (acc)
    );

    pmr_sleep_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .force_i      (force_q),
        .wake_hit_i   (|(wake_i & wake_en_q)),
        .asleep_o     (asleep),
        .enter_o      (enter),
        .wake_o       (wake_evt),
        .wake_pulse_o (wake_pulse_o)
    );

    pmr_gpio_mux #(.NUM_GPIO(NUM_GPIO)) u_gpio (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .capture_i (enter),
        .asleep_i  (asleep),
        .slp_val_i (gpio_slp_q),
        .norm_i    (gpio_norm_i),
        .gpio_o    (gpio_o)
    );

    pmr_osc_sync #(.STAGES(SYNC_STAGES)) u_osc (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .async_i  (osc_stable_i),
        .sticky_o (osc_ok_q)
    );

    // Writable state
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            force_q    <= 1'b0;
            cause_q    <= 1'b0;
            scratch_q  <= '0;
            wake_en_q  <= '0;
            cfg_q      <= '0;
            pll_q      <= PLL_RST;
            gpio_slp_q <= '0;
        end else begin
            // Set-only request bit, cleared by hardware at wake.
            if (wake_evt) begin
                force_q <= 1'b0;
            end else if (acc.wr && acc.idx == REG_CTRL && bus_wdata_i[FORCE_BIT]) begin
                force_q <= 1'b1;
            end
            // Cause bit: set on entry has priority over write-1-to-clear.
            if (enter) begin
                cause_q <= 1'b1;
            end else if (acc.wr && acc.idx == REG_STAT && bus_wdata_i[CAUSE_BIT]) begin
                cause_q <= 1'b0;
            end
            if (acc.wr) begin
                unique case (acc.idx)
                    REG_SCRATCH:  scratch_q  <= bus_wdata_i;
                    REG_WAKE_EN:  wake_en_q  <= bus_wdata_i[NUM_WAKE-1:0];
                    REG_CFG:      cfg_q      <= bus_wdata_i[CFG_W-1:0];
                    REG_PLL:      pll_q      <= bus_wdata_i[PLL_W-1:0];
                    REG_GPIO_SLP: gpio_slp_q <= bus_wdata_i[NUM_GPIO-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Read mux
    always_comb begin
        unique case (acc.idx)
            REG_CTRL:     rd_word = flag_word(force_q);
            REG_STAT:     rd_word = flag_word(cause_q);
            REG_SCRATCH:  rd_word = scratch_q;
            REG_WAKE_EN:  rd_word = DATA_W'(wake_en_q);
            REG_CFG:      rd_word = DATA_W'(cfg_q);
            REG_PLL:      rd_word = DATA_W'(pll_q);
            REG_GPIO_SLP: rd_word = DATA_W'(gpio_slp_q);
            REG_OSC:      rd_word = flag_word(osc_ok_q);
            default:      rd_word = '0;
        endcase
    end

    assign bus_rdata_o = acc.rd ? rd_word : '0;
    assign sleep_o     = asleep;
    assign cfg_o       = cfg_q;
    assign pll_cfg_o   = pll_q;

endmodule

// File: rtl/pmr_checker.sv
module pmr_checker #(
    parameter int ADDR_W   = 6,
    parameter int NUM_WAKE = 8,
    parameter int NUM_GPIO = 8
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                bus_sel_i,
    input logic                bus_wr_i,
    input logic [ADDR_W-1:0]   bus_addr_i,
    input logic [31:0]         bus_wdata_i,
    input logic [NUM_WAKE-1:0] wake_i,
    input logic [NUM_WAKE-1:0] wake_en,
    input logic [NUM_GPIO-1:0] gpio_norm_i,
    input logic [NUM_GPIO-1:0] gpio_o,
    input logic                sleep_o,
    input logic                wake_pulse_o,
    input logic                force_q,
    input logic                osc_ok
);

    logic ctrl_wr;
    assign ctrl_wr = bus_sel_i && bus_wr_i && (bus_addr_i[ADDR_W-1:2] == '0);

    a_r1_reset_quiet: assert property (@(posedge clk_i)
        rst_i |=> (!sleep_o && !wake_pulse_o && !force_q));

    a_r2_request_to_sleep: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_wr && bus_wdata_i[0] && !force_q && !sleep_o) |=> ##1 sleep_o);

    a_r3_zero_keeps_request: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_wr && !bus_wdata_i[0] && force_q && !sleep_o) |=> force_q);

    a_r4_wake_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_pulse_o |-> (!sleep_o && !force_q));

    a_r5_masked_stays: assert property (@(posedge clk_i) disable iff (rst_i)
        (sleep_o && !(|(wake_i & wake_en))) |=> sleep_o);

    a_r5_no_pulse_awake: assert property (@(posedge clk_i) disable iff (rst_i)
        !sleep_o |=> !wake_pulse_o);

    a_r8_awake_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        !sleep_o |-> (gpio_o == gpio_norm_i));

    a_r8_asleep_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (sleep_o && $past(sleep_o)) |-> $stable(gpio_o));

    a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_pulse_o |=> !wake_pulse_o);

    a_r10_osc_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        osc_ok |=> osc_ok);

endmodule

bind sleep_pwr_regs pmr_checker #(
    .ADDR_W   (ADDR_W),
    .NUM_WAKE (NUM_WAKE),
    .NUM_GPIO (NUM_GPIO)
) u_pmr_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .bus_sel_i    (bus_sel_i),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .wake_i       (wake_i),
    .wake_en      (wake_en_q),
    .gpio_norm_i  (gpio_norm_i),
    .gpio_o       (gpio_o),
    .sleep_o      (sleep_o),
    .wake_pulse_o (wake_pulse_o),
    .force_q      (force_q),
    .osc_ok       (osc_ok_q)
);

// File: tb/sleep_pwr_regs_tb_top.sv
module sleep_pwr_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;

    localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_SCR = 6'h08,
                           A_WEN  = 6'h0C, A_CFG  = 6'h10, A_PLL = 6'h14,
                           A_GSL  = 6'h18, A_OSC  = 6'h1C;

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        {1'b1, A_SCR,  32'hDEADBEEF, 32'h0},
        {1'b0, A_SCR,  32'h0,        32'hDEADBEEF},  // R7
        {1'b1, A_WEN,  32'hFFFFFFFF, 32'h0},
        {1'b0, A_WEN,  32'h0,        32'h000000FF},  // R3
        {1'b1, A_CFG,  32'hFFFFFFFF, 32'h0},
        {1'b0, A_CFG,  32'h0,        32'h0000000F},  // R12
        {1'b1, A_PLL,  32'hFFFFFFE3, 32'h0},
        {1'b0, A_PLL,  32'h0,        32'h00000003},  // R12
        {1'b1, A_GSL,  32'hFFFFFF5A, 32'h0},
        {1'b0, A_GSL,  32'h0,        32'h0000005A},  // R3
        {1'b1, 6'h20,  32'hFFFFFFFF, 32'h0},
        {1'b0, 6'h20,  32'h0,        32'h0},         // R11
        {1'b0, 6'h3C,  32'h0,        32'h0},         // R11
        {1'b1, A_CTRL, 32'hFFFFFFFE, 32'h0},
        {1'b0, A_CTRL, 32'h0,        32'h0},         // R3
        {1'b1, A_OSC,  32'hFFFFFFFF, 32'h0},
        {1'b0, A_OSC,  32'h0,        32'h0},         // R10
        {1'b0, 6'h0B,  32'h0,        32'hDEADBEEF}   // R11
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        sel, wr;
    logic [5:0]  addr;
    logic [31:0] wdata, rdata;
    logic [7:0]  wake, gnorm, gpio;
    logic        osc, slp, wpulse;
    logic [3:0]  cfg;
    logic [4:0]  pll;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_pwr_regs dut_i (
        .clk_i(clk), .rst_i(rst), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .wake_i(wake), .gpio_norm_i(gnorm), .gpio_o(gpio),
        .osc_stable_i(osc), .sleep_o(slp), .wake_pulse_o(wpulse),
        .cfg_o(cfg), .pll_cfg_o(pll)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; sel = 0; wr = 0; addr = '0; wdata = '0;
        wake = '0; gnorm = 8'hC3; osc = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 sleep", {31'b0, slp}, 32'h0);
        check("R1 pulse", {31'b0, wpulse}, 32'h0);
        check("R1 gpio", {24'b0, gpio}, 32'hC3);
        bus_read(A_CTRL, rd); check("R1 ctrl", rd, 32'h0);
        bus_read(A_SCR, rd);  check("R1 scratch", rd, 32'h0);
        bus_read(A_PLL, rd);  check("R1 pll", rd, 32'h7);
        bus_read(A_WEN, rd);  check("R1 wake_en", rd, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R3/R7/R10/R11/R12 vec%0d", i), rd, VECS[i].exp);
            end
        end
        check("R12 cfg_o", {28'b0, cfg}, 32'hF);
        check("R12 pll_cfg_o", {27'b0, pll}, 32'h3);

        // Sleep entry
        bus_write(A_WEN, 32'h04);
        bus_write(A_CTRL, 32'h1);
        check("R2 not yet asleep", {31'b0, slp}, 32'h0);
        @(negedge clk);
        check("R2 asleep", {31'b0, slp}, 32'h1);
        check("R8 gpio sleep", {24'b0, gpio}, 32'h5A);
        bus_read(A_CTRL, rd); check("R2 ctrl reads 1", rd, 32'h1);
        bus_read(A_STAT, rd); check("R6 cause set", rd, 32'h1);
        bus_write(A_GSL, 32'hFF);
        check("R8 snapshot held", {24'b0, gpio}, 32'h5A);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, rd); check("R3 zero write ignored", rd, 32'h1);

        // R5 masked wake line
        wake = 8'h01;
        repeat (3) @(negedge clk);
        check("R5 masked wake", {31'b0, slp}, 32'h1);
        check("R5 no pulse", {31'b0, wpulse}, 32'h0);
        wake = 8'h00;

        // Enabled wake
        @(negedge clk);
        wake = 8'h04;
        @(negedge clk);
        wake = 8'h00;
        check("R4 awake", {31'b0, slp}, 32'h0);
        check("R9 pulse high", {31'b0, wpulse}, 32'h1);
        check("R8 gpio normal", {24'b0, gpio}, 32'hC3);
        @(negedge clk);
        check("R9 pulse one cycle", {31'b0, wpulse}, 32'h0);
        bus_read(A_CTRL, rd); check("R4 request cleared", rd, 32'h0);
        bus_read(A_SCR, rd);  check("R7 retained", rd, 32'hDEADBEEF);

        // R6 write-1-to-clear
        bus_write(A_STAT, 32'hFFFFFFFE);
        bus_read(A_STAT, rd); check("R6 zero keeps", rd, 32'h1);
        bus_write(A_STAT, 32'h1);
        bus_read(A_STAT, rd); check("R6 one clears", rd, 32'h0);

        // R5 wake while awake
        wake = 8'h04;
        @(negedge clk);
        check("R5 awake no pulse", {31'b0, wpulse}, 32'h0);
        @(negedge clk);
        check("R5 awake stays", {31'b0, slp}, 32'h0);
        wake = 8'h00;

        // R10 oscillator sticky
        osc = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(A_OSC, rd); check("R10 osc set", rd, 32'h1);
        osc = 1'b0;
        repeat (4) @(negedge clk);
        bus_write(A_OSC, 32'h0);
        bus_read(A_OSC, rd); check("R10 osc sticky", rd, 32'h1);

        // R1 reset during sleep
        bus_write(A_CTRL, 32'h1);
        @(negedge clk);
        check("R2 asleep again", {31'b0, slp}, 32'h1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset leaves sleep", {31'b0, slp}, 32'h0);
        check("R1 reset gpio", {24'b0, gpio}, 32'hC3);
        bus_read(A_CTRL, rd); check("R1 ctrl after reset", rd, 32'h0);
        bus_read(A_OSC, rd);  check("R1 osc after reset", rd, 32'h0);
        bus_read(A_SCR, rd);  check("R1 scratch after reset", rd, 32'h0);

        finish_run();
    end

endmodule